// File: doc/BRIEF.md
# PHY Management Transaction Engine

This block carries out single register transactions towards an external PHY over the two-wire management interface (a clock line MDC and a bidirectional data line MDIO). Software controls it through two registers. The first is a packed command word that holds a busy flag, a direction flag, a PHY register index and a PHY address. The second is a 16-bit data register. For a write, software loads the data register first and then writes the command word with the busy flag set. For a read, software writes the command word only, and the result appears in the data register.

While a transaction is running, the engine produces MDC by dividing the system clock. It shifts a complete management frame out on MDIO, releases the line for the PHY's answer during a read, and then clears the busy flag. Requests that arrive while busy is set are refused. MDC does not toggle between transactions.

Top module: `mdio_mgmt_engine`

## Requirements
- R1: After reset both registers read zero, MDC is low and the MDIO output enable is low.
- R2: The command word decodes busy at bit 0, write-select at bit 1 (1 = write, 0 = read), the 5-bit register index at bits 10:6 and the 5-bit PHY address at bits 15:11. Reading it back returns these fields, and every other bit reads as zero.
- R3: A command write accepted with bit 0 set sets busy and starts exactly one frame. A command write accepted with bit 0 clear updates the fields and starts no frame.
- R4: Each frame is 64 MDC periods long. It carries 32 ones, then the start pair 0,1, then the opcode 1,0 for a read or 0,1 for a write, then the PHY address MSB first, then the register index MSB first.
- R5: In a write frame the turnaround is 1,0 and is followed by the low 16 bits of the data register, MSB first. MDIO is driven for all 64 bits.
- R6: In a read frame MDIO is released (output enable low) from the first turnaround bit to the end of the frame. The engine samples the 16 data bits on MDC rising edges, and the result is in the data register once busy reads zero.
- R7: One MDC half period lasts CLK_DIV system clocks. Busy reads one for 128*CLK_DIV+1 clock cycles after the accepting edge, and then clears by itself.
- R8: While busy is set, writes to the command word and writes to the data register are ignored. They change neither the register contents nor the frame in progress.
- R9: MDC stays low whenever busy reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_wr | input | 1 | Write strobe for the command word |
| data_wr | input | 1 | Write strobe for the data register |
| wdata | input | 32 | Write data shared by both registers |
| acc_rdata | output | 16 | Command word readback |
| data_rdata | output | 16 | Data register readback |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (1 = driven) |
| mdio_i | input | 1 | MDIO input value |

## Verification
The assertions check four properties on every cycle: MDC is quiet while not busy, the command fields and data register are frozen during a transaction, busy clears right after frame completion, and the output enable follows the write or read direction bit by bit. Other behaviour can only be shown by the bench scenarios. These cover the exact bit content of each frame, the value a read places in the data register, the frame duration, and the fact that refused writes leave neither a trace in the registers nor a second frame. A behavioural PHY in the bench decodes every frame against a queue of expected commands. It also answers reads from its own register image.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  // command word field positions (software-visible layout)
  localparam int CMD_BUSY_BIT  = 0;
  localparam int CMD_WRITE_BIT = 1;
  localparam int CMD_REG_LSB   = 6;
  localparam int CMD_PHY_LSB   = 11;
  localparam int FIELD_W       = 5;
  localparam int MD_DATA_W     = 16;

  typedef struct packed {
    logic [FIELD_W-1:0] phy;
    logic [FIELD_W-1:0] regi;
    logic               wr;
  } mdio_cmd_t;
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CNT_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [CNT_W-1:0] cnt;
  logic             tick;

  assign tick      = en && (cnt == CNT_W'(CLK_DIV - 1));
  assign rise_tick = tick && !mdc;
  assign fall_tick = tick && mdc;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  mdio_cmd_t            cmd,
  input  logic [MD_DATA_W-1:0] wr_data,
  input  logic                 rise_tick,
  input  logic                 fall_tick,
  input  logic                 mdio_i,
  output logic                 running,
  output logic                 done,
  output logic [MD_DATA_W-1:0] rd_data,
  output logic                 mdio_o,
  output logic                 mdio_oe
);
  localparam int FRAME_LEN = PRE_LEN + 32;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam int TA_IDX    = PRE_LEN + 14;
  localparam int DATA_IDX  = PRE_LEN + 16;

  logic [FRAME_LEN-1:0] shreg;
  logic [FRAME_LEN-1:0] load_vec;
  logic [IDX_W-1:0]     idx;
  logic [IDX_W-1:0]     nidx;
  logic                 is_wr;

  assign load_vec = {{PRE_LEN{1'b1}}, 2'b01,
                     cmd.wr ? 2'b01 : 2'b10,
                     cmd.phy, cmd.regi,
                     cmd.wr ? 2'b10 : 2'b11,
                     cmd.wr ? wr_data : {MD_DATA_W{1'b1}}};
  assign nidx = idx + IDX_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      done    <= 1'b0;
      idx     <= '0;
      shreg   <= '0;
      is_wr   <= 1'b0;
      rd_data <= '0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !running) begin
        running <= 1'b1;
        idx     <= '0;
        shreg   <= load_vec;
        is_wr   <= cmd.wr;
        mdio_o  <= load_vec[FRAME_LEN-1];
        mdio_oe <= 1'b1;
      end else if (running) begin
        if (rise_tick && !is_wr && idx >= IDX_W'(DATA_IDX))
          rd_data <= {rd_data[MD_DATA_W-2:0], mdio_i};
        if (fall_tick) begin
          if (idx == IDX_W'(FRAME_LEN - 1)) begin
            running <= 1'b0;
            done    <= 1'b1;
            mdio_o  <= 1'b0;
            mdio_oe <= 1'b0;
          end else begin
            idx     <= nidx;
            shreg   <= shreg << 1;
            mdio_o  <= shreg[FRAME_LEN-2];
            mdio_oe <= is_wr || (nidx < IDX_W'(TA_IDX));
          end
        end
      end
    end
  end

  // R5: a write frame keeps MDIO driven throughout
  p_write_driven_r5: assert property (@(posedge clk) disable iff (rst)
    running && is_wr |-> mdio_oe);
  // R6: a read frame has MDIO released from the turnaround onwards
  p_read_release_r6: assert property (@(posedge clk) disable iff (rst)
    running && !is_wr && idx >= IDX_W'(TA_IDX) |-> !mdio_oe);
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 acc_wr,
  input  logic                 data_wr,
  input  logic [31:0]          wdata,
  input  logic                 done,
  input  logic [MD_DATA_W-1:0] rd_data,
  output logic                 start,
  output mdio_cmd_t            start_cmd,
  output logic [MD_DATA_W-1:0] data_q,
  output logic                 busy,
  output logic [15:0]          acc_rdata
);
  mdio_cmd_t cmd_q;
  logic      unused_wbits;

  assign unused_wbits = ^{wdata[31:16], wdata[CMD_REG_LSB-1:CMD_WRITE_BIT+1]};

  assign start_cmd.wr   = wdata[CMD_WRITE_BIT];
  assign start_cmd.regi = wdata[CMD_REG_LSB +: FIELD_W];
  assign start_cmd.phy  = wdata[CMD_PHY_LSB +: FIELD_W];
  assign start          = acc_wr && !busy && wdata[CMD_BUSY_BIT];

  always_comb begin
    acc_rdata = '0;
    acc_rdata[CMD_BUSY_BIT]               = busy;
    acc_rdata[CMD_WRITE_BIT]              = cmd_q.wr;
    acc_rdata[CMD_REG_LSB +: FIELD_W]     = cmd_q.regi;
    acc_rdata[CMD_PHY_LSB +: FIELD_W]     = cmd_q.phy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      cmd_q  <= '0;
      data_q <= '0;
    end else if (done) begin
      busy <= 1'b0;
      if (!cmd_q.wr) data_q <= rd_data;
    end else if (!busy) begin
      if (acc_wr) begin
        cmd_q <= start_cmd;
        busy  <= wdata[CMD_BUSY_BIT];
      end
      if (data_wr) data_q <= wdata[MD_DATA_W-1:0];
    end
  end

  // R7: completion releases busy on the next edge
  p_done_clears_busy_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);
  // R8: fields and data stay frozen while a transaction runs
  p_frozen_while_busy_r8: assert property (@(posedge clk) disable iff (rst)
    busy && !done |=> $stable(cmd_q) && $stable(data_q));
endmodule

// File: rtl/mdio_mgmt_engine.sv
module mdio_mgmt_engine
  import mdio_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        acc_wr,
  input  logic        data_wr,
  input  logic [31:0] wdata,
  output logic [15:0] acc_rdata,
  output logic [15:0] data_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic                 start;
  mdio_cmd_t            start_cmd;
  logic [MD_DATA_W-1:0] data_q;
  logic [MD_DATA_W-1:0] rd_data;
  logic                 busy;
  logic                 running;
  logic                 done;
  logic                 rise_tick;
  logic                 fall_tick;

  mdio_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .acc_wr    (acc_wr),
    .data_wr   (data_wr),
    .wdata     (wdata),
    .done      (done),
    .rd_data   (rd_data),
    .start     (start),
    .start_cmd (start_cmd),
    .data_q    (data_q),
    .busy      (busy),
    .acc_rdata (acc_rdata)
  );

  mdio_clkdiv #(.CLK_DIV(CLK_DIV)) u_clkdiv (
    .clk       (clk),
    .rst       (rst),
    .en        (running),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mdio_frame #(.PRE_LEN(PRE_LEN)) u_frame (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .cmd       (start_cmd),
    .wr_data   (data_q),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .mdio_i    (mdio_i),
    .running   (running),
    .done      (done),
    .rd_data   (rd_data),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
  );

  assign data_rdata = data_q;

  // R9: the management clock is quiet whenever the engine is not busy
  p_mdc_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc);
endmodule

// File: tb/mdio_mgmt_engine_tb_top.sv
`timescale 1ns/1ps
module mdio_mgmt_engine_tb_top;
  localparam int DIV = 4;
  localparam int DUR = 128 * DIV + 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_wr = 1'b0;
  logic        data_wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [15:0] acc_rdata, data_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  always #2 clk = ~clk;

  mdio_mgmt_engine #(.CLK_DIV(DIV), .PRE_LEN(32)) dut_i (
    .clk(clk), .rst(rst), .acc_wr(acc_wr), .data_wr(data_wr), .wdata(wdata),
    .acc_rdata(acc_rdata), .data_rdata(data_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  typedef struct { bit wr; bit [4:0] phy; bit [4:0] rg; bit [15:0] d; } exp_t;
  exp_t exp_q[$];

  int checks = 0, failures = 0, frames_seen = 0, frames_started = 0;
  int rises_total = 0, idle_viol = 0;
  bit finished = 0;
  logic [15:0] phy_mem [32];
  logic [15:0] shadow  [32];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // behavioural PHY + frame monitor, sampled at falling system-clock edges
  logic [63:0] cap;
  int  rc = 0;
  bit  cur_wr = 0, oe_bad = 0;
  logic [15:0] resp = '0;
  logic mdc_prev = 1'b0;
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && !acc_rdata[0] && mdc) idle_viol++;
      if (mdc && !mdc_prev) begin
        rises_total++;
        cap[63-rc] = mdio_o;
        if (rc < 46 && !mdio_oe) oe_bad = 1;
        if (rc >= 46 && (cur_wr != mdio_oe)) oe_bad = 1;
        rc++;
        if (rc == 36) cur_wr = (cap[29:28] == 2'b01);
        if (rc == 46) resp = phy_mem[cap[22:18]] ^ {11'b0, cap[27:23]};
        if (rc == 64) begin
          exp_t e;
          logic [63:0] ev;
          frames_seen++;
          if (exp_q.size() == 0) begin
            chk(0, "R3 unexpected frame", cap, 64'h0);
          end else begin
            e = exp_q.pop_front();
            ev = {32'hFFFF_FFFF, 2'b01, e.wr ? 2'b01 : 2'b10, e.phy, e.rg, 2'b10, e.d};
            chk(cap[63:18] == ev[63:18], "R4 frame header", cap, ev);
            if (e.wr) begin
              chk(cap[17:0] == ev[17:0], "R5 write turnaround/data", {46'h0, cap[17:0]}, {46'h0, ev[17:0]});
              phy_mem[e.rg] = cap[15:0];
            end
            chk(!oe_bad, "R5/R6 output enable pattern", {63'h0, oe_bad}, 64'h0);
          end
          rc = 0; oe_bad = 0;
        end
      end
      if (!mdc && mdc_prev) begin
        if (!cur_wr && rc == 47) mdio_i = 1'b0;
        else if (!cur_wr && rc >= 48 && rc <= 63) mdio_i = resp[63-rc];
        else mdio_i = 1'b1;
      end
      mdc_prev = mdc;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_acc(input logic [31:0] w);
    @(negedge clk); acc_wr = 1'b1; wdata = w;
    @(negedge clk); acc_wr = 1'b0; wdata = '0;
  endtask

  task automatic wr_data(input logic [15:0] d);
    @(negedge clk); data_wr = 1'b1; wdata = {16'h0, d};
    @(negedge clk); data_wr = 1'b0; wdata = '0;
  endtask

  function automatic logic [31:0] cmdw(input bit wr, input bit [4:0] phy, input bit [4:0] rg, input bit go);
    return {16'h0, phy, rg, 4'h0, wr, go};
  endfunction

  task automatic wait_idle(output int n);
    n = 0;
    while (acc_rdata[0]) begin n++; @(negedge clk); end
  endtask

  task automatic xfer(input bit wr, input bit [4:0] phy, input bit [4:0] rg, input bit [15:0] d);
    exp_t e;
    int n;
    logic [15:0] expd;
    e.wr = wr; e.phy = phy; e.rg = rg; e.d = wr ? d : 16'h0;
    if (wr) wr_data(d);
    exp_q.push_back(e);
    frames_started++;
    @(negedge clk); acc_wr = 1'b1; wdata = cmdw(wr, phy, rg, 1'b1);
    @(negedge clk); acc_wr = 1'b0; wdata = '0;
    chk(acc_rdata == cmdw(wr, phy, rg, 1'b1), "R2 readback while busy", {48'h0, acc_rdata}, {32'h0, cmdw(wr, phy, rg, 1'b1)});
    wait_idle(n);
    chk(n == DUR, "R7 busy duration", n, DUR);
    if (wr) begin
      shadow[rg] = d;
      chk(data_rdata == d, "R5 data kept after write", data_rdata, d);
    end else begin
      expd = shadow[rg] ^ {11'b0, phy};
      chk(data_rdata == expd, "R6 read result", data_rdata, expd);
    end
  endtask

  initial begin
    #(200000 * 4);
    chk(0, "watchdog expired", 0, 1);
    report();
  end

  initial begin
    int n;
    for (int i = 0; i < 32; i++) begin
      phy_mem[i] = {5'(i), 5'(31 - i), 6'h2A};
      shadow[i]  = {5'(i), 5'(31 - i), 6'h2A};
    end
    cyc(5);
    rst = 1'b0;
    cyc(1);
    // R1 reset state
    chk(acc_rdata == 16'h0 && data_rdata == 16'h0, "R1 registers after reset", {acc_rdata, data_rdata}, 0);
    chk(!mdc && !mdio_oe, "R1 mdc/oe after reset", {mdc, mdio_oe}, 0);

    // R2/R3: field-only write, junk in reserved bits, no frame
    wr_acc(32'hABCD_003C | cmdw(1'b1, 5'd3, 5'd7, 1'b0));
    chk(acc_rdata == cmdw(1'b1, 5'd3, 5'd7, 1'b0), "R2 field layout readback", acc_rdata, cmdw(1'b1, 5'd3, 5'd7, 1'b0));
    n = rises_total;
    cyc(60);
    chk(rises_total == n, "R3 no frame without busy bit", rises_total, n);

    // main transactions
    xfer(1'b1, 5'd1, 5'd4, 16'hA5C3);
    xfer(1'b0, 5'd1, 5'd4, 16'h0);
    xfer(1'b0, 5'd31, 5'd31, 16'h0);
    xfer(1'b0, 5'd0, 5'd0, 16'h0);
    xfer(1'b1, 5'd16, 5'd17, 16'h0001);
    xfer(1'b0, 5'd16, 5'd17, 16'h0);
    xfer(1'b1, 5'd10, 5'd21, 16'hFFFF);

    // R8: refused writes during a read
    begin
      exp_t e;
      logic [15:0] expd;
      e.wr = 0; e.phy = 5'd2; e.rg = 5'd9; e.d = 16'h0;
      exp_q.push_back(e); frames_started++;
      wr_acc(cmdw(1'b0, 5'd2, 5'd9, 1'b1));
      cyc(20);
      wr_acc(cmdw(1'b1, 5'd7, 5'd3, 1'b1));
      chk(acc_rdata == cmdw(1'b0, 5'd2, 5'd9, 1'b1), "R8 command write refused", acc_rdata, cmdw(1'b0, 5'd2, 5'd9, 1'b1));
      wr_data(16'hBEEF);
      wait_idle(n);
      expd = shadow[9] ^ 16'd2;
      chk(data_rdata == expd, "R8 data write refused during read", data_rdata, expd);
    end

    // R8: data write refused during a write frame
    begin
      exp_t e;
      wr_data(16'h1357);
      e.wr = 1; e.phy = 5'd5; e.rg = 5'd12; e.d = 16'h1357;
      exp_q.push_back(e); frames_started++;
      wr_acc(cmdw(1'b1, 5'd5, 5'd12, 1'b1));
      cyc(30);
      wr_data(16'h2468);
      wait_idle(n);
      shadow[12] = 16'h1357;
      chk(data_rdata == 16'h1357, "R8 data register unchanged", data_rdata, 16'h1357);
    end

    cyc(100);
    chk(frames_seen == frames_started && exp_q.size() == 0, "R3 one frame per start", frames_seen, frames_started);
    chk(idle_viol == 0, "R9 mdc quiet when idle", idle_viol, 0);
    chk(!mdio_oe, "R6 line released when idle", mdio_oe, 0);
    report();
  end
endmodule